// File: doc/BRIEF.md
# Adaptive Flash Refresh Scheduler

This block sets the refresh policy for a multi-level-cell NAND flash array. It counts host program/erase (P/E) events over a window of day ticks and, at the end of each window, judges whether the workload cycles each erase block more than once a day. When it does, refresh is relocation during normal data updates, with a one-day interval. When it does not, refresh is in-place reprogramming at an interval taken from the discrete set {1, 2, 3, 7, 21} days. That interval is the largest one that is no more than half the measured P/E interval, stays within a parity budget, and needs no more correction strength than the ECC engine has.

Each block has an idle-day counter. A host P/E on the block clears it, and so does a completed refresh of the block. On every day tick a scan pointer walks the blocks in ascending order. Each block whose idle count has reached the current interval gets a refresh command to the flash sequencer over a valid/ready handshake. Only one command is in flight at a time. The block also outputs the BCH correction strength that even and odd pages need for the chosen interval.

Top module: `flash_refresh_sched`

## Requirements
- R1: After reset `cmd_valid` and `mode_high` are 0, and the stored window count and window length are 0. With `ecc_t_avail`=6 and `par_cap`=64 the interval is therefore 21 days.
- R2: A window closes on the day tick at which the number of ticks in the window reaches `win_days`. At that tick `mode_high` becomes 1 exactly when the P/E events counted in the window exceed `NUM_BLK`×`win_days`.
- R3: While `mode_high` is 1, `interval_days` is 1, `t_even`=`t_odd`=3, and refresh commands carry `cmd_inplace`=0 (relocation).
- R4: While `mode_high` is 0, `interval_days` is the largest I in {1,2,3,7,21} that meets all three of these conditions. First, 2×I×(last window count) ≤ `NUM_BLK`×(last window length). Second, 10×t_odd(I) ≤ `par_cap`. Third, t_odd(I) ≤ `ecc_t_avail`. If no I qualifies, `interval_days` is 1.
- R5: The strength outputs follow the interval. At 1 or 2 days even and odd are both 3. At 3 days both are 4. At 7 days even is 4 and odd is 5. At 21 days even is 5 and odd is 6.
- R6: Each block's idle count rises by one per day tick and saturates at 255. A P/E event on the block, or a completed refresh handshake for it, sets the count to 0.
- R7: A day tick starts a scan of blocks 0 to `NUM_BLK`-1 in order. Each block whose idle count is at least `interval_days` gets exactly one command. `cmd_inplace` is 1 in low-rate mode. A pending command holds its block and kind stable until `cmd_ready` is high, and blocks that do not qualify get no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| day_tick | input | 1 | One-cycle pulse per elapsed day |
| pe_valid | input | 1 | Host P/E event strobe |
| pe_blk | input | IDX_W | Block of the P/E event |
| win_days | input | WIN_W | Rate-measurement window length in days |
| ecc_t_avail | input | 3 | Highest BCH correction strength available |
| par_cap | input | 7 | Parity bits allowed per 512 data bits |
| cmd_valid | output | 1 | Refresh command pending |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_blk | output | IDX_W | Block to refresh |
| cmd_inplace | output | 1 | 1 = in-place reprogram, 0 = relocation |
| mode_high | output | 1 | Workload judged above one P/E per block per day |
| interval_days | output | 5 | Current refresh interval in days |
| t_even | output | 3 | BCH strength for even pages |
| t_odd | output | 3 | BCH strength for odd pages |

## Verification
The bench builds the block with `NUM_BLK`=4 and windows of 1 to 4 days. With these values the rate boundary (blocks × window) sits at a handful of events, so a few random events per day switch between both modes and between every interval from 1 to 21 days. The small block count also keeps each scan short enough that hundreds of days fit in the run. Directed steps put the count exactly at and one above the boundary. They also sweep the parity cap and available strength so that every interval is chosen, including the fallback to one day.

// File: rtl/flash_refresh_sched.sv
module flash_refresh_sched #(
  parameter int NUM_BLK = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 8,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             day_tick,
  input  logic             pe_valid,
  input  logic [IDX_W-1:0] pe_blk,
  input  logic [WIN_W-1:0] win_days,
  input  logic [2:0]       ecc_t_avail,
  input  logic [6:0]       par_cap,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [IDX_W-1:0] cmd_blk,
  output logic             cmd_inplace,
  output logic             mode_high,
  output logic [4:0]       interval_days,
  output logic [2:0]       t_even,
  output logic [2:0]       t_odd
);
  localparam logic [4:0][4:0] CAND   = {5'd21, 5'd7, 5'd3, 5'd2, 5'd1};
  localparam logic [4:0][2:0] T_ODD  = {3'd6, 3'd5, 3'd4, 3'd3, 3'd3};
  localparam logic [4:0][2:0] T_EVEN = {3'd5, 3'd4, 3'd4, 3'd3, 3'd3};
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]       idle [NUM_BLK];
  logic [CNT_W-1:0] ev_cnt, last_cnt;
  logic [WIN_W-1:0] day_cnt, last_win;
  logic             scanning;
  logic [IDX_W-1:0] ptr;
  logic [2:0]       sel;

  wire closing = day_tick && ((WIN_W+1)'(day_cnt) + 1'b1 >= (WIN_W+1)'(win_days));
  wire handshake = cmd_valid && cmd_ready;
  wire last_blk = (ptr == IDX_W'(NUM_BLK - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_cnt <= '0; last_cnt <= '0; day_cnt <= '0; last_win <= '0; mode_high <= 1'b0;
    end else begin
      if (closing) begin
        last_cnt  <= ev_cnt;
        last_win  <= win_days;
        mode_high <= (32'(ev_cnt) > 32'(NUM_BLK) * 32'(win_days));
        ev_cnt    <= pe_valid ? CNT_W'(1) : '0;
        day_cnt   <= '0;
      end else begin
        if (day_tick) day_cnt <= day_cnt + 1'b1;
        if (pe_valid && ev_cnt != CNT_MAX) ev_cnt <= ev_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    sel = 3'd0;
    if (!mode_high)
      for (int i = 1; i < 5; i++)
        if (2 * 32'(CAND[i]) * 32'(last_cnt) <= 32'(NUM_BLK) * 32'(last_win) &&
            10 * 32'(T_ODD[i]) <= 32'(par_cap) && T_ODD[i] <= ecc_t_avail)
          sel = 3'(i);
  end

  assign interval_days = CAND[sel];
  assign t_even        = T_EVEN[sel];
  assign t_odd         = T_ODD[sel];

  always_comb assert (t_even <= t_odd);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_idle
    always_ff @(posedge clk) begin
      if (!rst_n) idle[b] <= '0;
      else if ((pe_valid && pe_blk == IDX_W'(b)) || (handshake && cmd_blk == IDX_W'(b)))
        idle[b] <= '0;
      else if (day_tick && idle[b] != 8'd255)
        idle[b] <= idle[b] + 1'b1;
    end

    p_idle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle[b] != 8'd0 |=> idle[b] == 8'd0 || idle[b] >= $past(idle[b]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanning <= 1'b0; ptr <= '0; cmd_valid <= 1'b0; cmd_blk <= '0; cmd_inplace <= 1'b0;
    end else if (cmd_valid) begin
      if (cmd_ready) begin
        cmd_valid <= 1'b0;
        if (last_blk) scanning <= 1'b0;
        else ptr <= ptr + 1'b1;
      end
    end else if (scanning) begin
      if (idle[ptr] >= 8'(interval_days)) begin
        cmd_valid   <= 1'b1;
        cmd_blk     <= ptr;
        cmd_inplace <= !mode_high;
      end else if (last_blk) scanning <= 1'b0;
      else ptr <= ptr + 1'b1;
    end else if (day_tick) begin
      scanning <= 1'b1;
      ptr      <= '0;
    end
  end

  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_blk) && $stable(cmd_inplace));
  p_high_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_high |-> interval_days == 5'd1 && t_even == 3'd3 && t_odd == 3'd3);
  p_t_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    interval_days != 5'd1 |-> t_odd <= ecc_t_avail && 10 * 32'(t_odd) <= 32'(par_cap));
  p_pe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pe_valid |=> idle[$past(pe_blk)] == 8'd0);
  p_cmd_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> idle[cmd_blk] != 8'd0);
endmodule

// File: tb/flash_refresh_sched_test.sv
module flash_refresh_sched_test;
  localparam int NB = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0, day_tick = 0, pe_valid = 0, cmd_ready = 0;
  logic [IW-1:0] pe_blk = '0;
  logic [7:0] win_days = 8'd1;
  logic [2:0] ecc_t_avail = 3'd6;
  logic [6:0] par_cap = 7'd64;
  logic cmd_valid, cmd_inplace, mode_high;
  logic [IW-1:0] cmd_blk;
  logic [4:0] interval_days;
  logic [2:0] t_even, t_odd;

  flash_refresh_sched #(.NUM_BLK(NB), .CNT_W(16), .WIN_W(8)) uut (
    .clk, .rst_n, .day_tick, .pe_valid, .pe_blk, .win_days, .ecc_t_avail, .par_cap,
    .cmd_valid, .cmd_ready, .cmd_blk, .cmd_inplace, .mode_high, .interval_days, .t_even, .t_odd);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  int idle_m[NB];
  int evc = 0, wd = 0, lcnt = 0, lwin = 0;
  bit hi = 0;

  function automatic int todd(int iv);
    case (iv) 1, 2: return 3; 3: return 4; 7: return 5; default: return 6; endcase
  endfunction
  function automatic int teven(int iv);
    case (iv) 1, 2: return 3; 3, 7: return 4; default: return 5; endcase
  endfunction
  function automatic int exp_iv();
    int best = 1;
    int opts[5] = '{1, 2, 3, 7, 21};
    if (hi) return 1;
    foreach (opts[k])
      if (2 * opts[k] * lcnt <= NB * lwin && 10 * todd(opts[k]) <= int'(par_cap) &&
          todd(opts[k]) <= int'(ecc_t_avail))
        best = opts[k];
    return best;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_policy(string req);
    int iv = exp_iv();
    check(int'(interval_days) == iv, {req, " interval"}, interval_days, iv);
    check(int'(t_even) == teven(iv), "R5 t_even", t_even, teven(iv));
    check(int'(t_odd) == todd(iv), "R5 t_odd", t_odd, todd(iv));
  endtask

  task automatic pe_ev(int b);
    @(negedge clk);
    pe_valid = 1; pe_blk = IW'(b);
    idle_m[b] = 0; evc++;
    @(negedge clk);
    pe_valid = 0;
  endtask

  task automatic do_day(int nev);
    int expb[NB];
    int ne = 0;
    for (int k = 0; k < nev; k++) pe_ev($urandom % NB);
    @(negedge clk);
    day_tick = 1;
    for (int b = 0; b < NB; b++) if (idle_m[b] < 255) idle_m[b]++;
    if (wd + 1 >= int'(win_days)) begin
      lcnt = evc; lwin = int'(win_days); hi = (evc > NB * int'(win_days)); evc = 0; wd = 0;
    end else wd++;
    @(negedge clk);
    day_tick = 0;
    check(mode_high == hi, "R2 mode", mode_high, hi);
    check_policy(hi ? "R3" : "R4");
    for (int b = 0; b < NB; b++) if (idle_m[b] >= exp_iv()) expb[ne++] = b;
    for (int i = 0; i < ne; i++) begin
      bit got = 0;
      int waitc = 0;
      while (!got && waitc < 60) begin
        if (waitc > 0) @(negedge clk);
        cmd_ready = 0;
        if (cmd_valid) begin
          check(int'(cmd_blk) == expb[i], "R7 block order", cmd_blk, expb[i]);
          check(cmd_inplace == !hi, hi ? "R3 relocation" : "R7 in-place", cmd_inplace, !hi);
          if ($urandom % 3 != 0) begin cmd_ready = 1; got = 1; idle_m[expb[i]] = 0; end
        end
        waitc++;
      end
      check(got, "R7 command issued", got, 1);
      @(negedge clk);
      cmd_ready = 0;
    end
    for (int k = 0; k < NB + 3; k++) begin
      check(!cmd_valid, "R7 no extra command", cmd_valid, 0);
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (idle_m[b]) idle_m[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!cmd_valid, "R1 cmd_valid", cmd_valid, 0);
    check(!mode_high, "R1 mode_high", mode_high, 0);
    check(interval_days == 5'd21, "R1 interval", interval_days, 21);
    check_policy("R1");
    ecc_t_avail = 3'd4; @(negedge clk); check_policy("R4 t_avail4");
    ecc_t_avail = 3'd5; @(negedge clk); check_policy("R4 t_avail5");
    ecc_t_avail = 3'd6; par_cap = 7'd49; @(negedge clk); check_policy("R4 cap49");
    par_cap = 7'd59; @(negedge clk); check_policy("R4 cap59");
    par_cap = 7'd29; @(negedge clk);
    check(interval_days == 5'd1, "R4 fallback", interval_days, 1);
    check_policy("R4 cap29");
    par_cap = 7'd64; ecc_t_avail = 3'd2; @(negedge clk); check_policy("R4 t_avail2");
    ecc_t_avail = 3'd6; @(negedge clk);

    win_days = 8'd1;
    do_day(0);
    do_day(NB);
    check(!mode_high, "R2 boundary equal", mode_high, 0);
    do_day(NB + 1);
    check(mode_high, "R2 boundary above", mode_high, 1);
    do_day(0);

    for (int d = 0; d < 300; d++) begin
      int r = $urandom % 10;
      if (wd == 0 && $urandom % 4 == 0) win_days = 8'(1 + $urandom % 4);
      if ($urandom % 8 == 0) ecc_t_avail = 3'(3 + $urandom % 4);
      if ($urandom % 8 == 0) par_cap = 7'(40 + $urandom % 25);
      do_day(r < 5 ? 0 : (r < 7 ? 1 : int'($urandom % 9)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule